// File: doc/BRIEF.md
# Oscillator Divider and Rate Selector

This block is the countdown chain of a real-time clock's timebase. A one-cycle enable, pulsed once per period of a 32.768 kHz oscillator, advances a 15-stage binary divider. A 4-bit rate code picks one of the divider taps through a 16-way multiplexer. The chosen tap drives two outputs. The first is a square-wave output, which a square-wave enable can switch off. The second is a single-cycle periodic event pulse, which goes to interrupt logic outside this block.

A 3-bit divider-control field sets how the chain operates:
- With one pattern the chain counts ticks.
- With a second family of patterns the oscillator keeps running but the divider is held at zero, so software can restart the timebase from a known phase.
- All other patterns model a stopped oscillator. Ticks are ignored and the divider keeps its count.

Both outputs are registered. They change one clock after the tick or control change that causes them.

Top module: `osc_rate_gen`

## Requirements
- R1: With divider control 3'b010 the divider counts up by one on every clock in which `osc_tick` is 1. The divider stays unchanged on clocks without a tick.
- R2: With divider control 3'b110 or 3'b111 the divider is forced to zero. While this mode lasts, `sq_out` stays 0 and `periodic_evt` stays 0.
- R3: Every other divider-control value (3'b000, 001, 011, 100, 101) ignores ticks and keeps the divider value. In these modes `sq_out` is 0 and no event occurs. When the control returns to 3'b010, counting resumes from the kept value.
- R4: Rate codes 1 and 2 select the 256 Hz tap (divider bit 6) and the 128 Hz tap (divider bit 7).
- R5: Rate codes 3 to 15 select divider bit (code − 2). This runs from 8192 Hz at code 3 down to 2 Hz at code 15.
- R6: Rate code 0 selects no tap. `sq_out` is 0 and no event is produced.
- R7: `sq_out` equals the selected divider bit, registered one clock after the divider update, only when `sq_en` is 1 and the control is 3'b010. Otherwise `sq_out` is 0.
- R8: `periodic_evt` is a one-clock pulse in the clock where the selected divider bit goes from 0 to 1. In a running chain with `sq_en` at 1, this is the same clock in which `sq_out` rises.
- R9: A rate-code change produces no event by itself. The next event comes at the next 0-to-1 transition of the newly selected bit.
- R10: While `rst` is high, and in the first clock after it, the divider is zero and both outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| osc_tick | input | 1 | One-cycle pulse per oscillator period |
| div_ctrl | input | 3 | Divider control: run, hold at zero, or oscillator off |
| rate_sel | input | 4 | Tap selection code for the multiplexer |
| sq_en | input | 1 | Square-wave output enable |
| sq_out | output | 1 | Gated square wave from the selected tap |
| periodic_evt | output | 1 | One-cycle pulse on each rising edge of the selected tap |

## Verification
A wrong divider count shows at `sq_out` within one period of the selected tap. The fast 8192 Hz tap exposes it within four ticks, and slow codes take up to 16384 ticks. A hold or stop mode that leaks ticks shows as a shifted phase once the chain runs again, at the first edge of the selected tap. A wrong tap decode shows as a wrong period on the first full cycle after the code is applied. A spurious event from a rate change shows in the very next clock.

// File: rtl/osc_div_pkg.sv
package osc_div_pkg;

  localparam int CTRL_W = 3;
  localparam logic [CTRL_W-1:0] CTRL_RUN_PAT = 3'b010;

  typedef enum logic [1:0] {
    OSC_OFF  = 2'd0,
    OSC_RUN  = 2'd1,
    OSC_HOLD = 2'd2
  } osc_mode_e;

  function automatic osc_mode_e decode_ctrl(input logic [CTRL_W-1:0] ctrl);
    if (ctrl == CTRL_RUN_PAT)
      return OSC_RUN;
    else if (ctrl[CTRL_W-1:CTRL_W-2] == 2'b11)
      return OSC_HOLD;
    else
      return OSC_OFF;
  endfunction

endpackage

// File: rtl/osc_div_ctrl.sv
module osc_div_ctrl
  import osc_div_pkg::*;
(
  input  logic [CTRL_W-1:0] div_ctrl,
  output osc_mode_e         mode
);

  always_comb begin
    mode = decode_ctrl(div_ctrl);
  end

endmodule

// File: rtl/osc_div_chain.sv
module osc_div_chain
  import osc_div_pkg::*;
#(
  parameter int DIV_W = 15
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             osc_tick,
  input  osc_mode_e        mode,
  output logic [DIV_W-1:0] cnt_nxt,
  output logic [DIV_W-1:0] rise_vec
);

  logic [DIV_W-1:0] cnt_q;
  logic             adv;

  assign adv = (mode == OSC_RUN) && osc_tick;

  always_comb begin
    if (mode == OSC_HOLD)
      cnt_nxt = '0;
    else if (adv)
      cnt_nxt = cnt_q + 1'b1;
    else
      cnt_nxt = cnt_q;
  end

  always_ff @(posedge clk) begin
    if (rst)
      cnt_q <= '0;
    else
      cnt_q <= cnt_nxt;
  end

  // A stage rises when the increment carries into it while it is low
  genvar k;
  generate
    for (k = 0; k < DIV_W; k++) begin : g_rise
      if (k == 0) begin : g_lsb
        assign rise_vec[k] = adv && !cnt_q[0];
      end else begin : g_upper
        assign rise_vec[k] = adv && !cnt_q[k] && (&cnt_q[k-1:0]);
      end
    end
  endgenerate

  // R2
  hold_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (mode == OSC_HOLD) |=> (cnt_q == '0));

  // R3
  off_frozen_chk: assert property (@(posedge clk) disable iff (rst)
    (mode == OSC_OFF) |=> $stable(cnt_q));

  // R1
  run_step_chk: assert property (@(posedge clk) disable iff (rst)
    (mode == OSC_RUN && osc_tick) |=> (cnt_q == $past(cnt_q) + 1'b1));

endmodule

// File: rtl/osc_rate_mux.sv
module osc_rate_mux #(
  parameter int DIV_W      = 15,
  parameter int SEL_W      = 4,
  parameter int SLOW_TAP   = 6,
  parameter int FAST_TAP   = 1,
  parameter int FAST_FIRST = 3
) (
  input  logic [SEL_W-1:0] rate_sel,
  input  logic [DIV_W-1:0] cnt_nxt,
  input  logic [DIV_W-1:0] rise_vec,
  output logic             tap_lvl,
  output logic             tap_rise
);

  function automatic int tap_index(input logic [SEL_W-1:0] sel);
    int s;
    s = int'(sel);
    if (s == 0)
      return -1;
    else if (s < FAST_FIRST)
      return SLOW_TAP + s - 1;
    else
      return FAST_TAP + s - FAST_FIRST;
  endfunction

  int idx;

  always_comb begin
    idx      = tap_index(rate_sel);
    tap_lvl  = 1'b0;
    tap_rise = 1'b0;
    for (int k = 0; k < DIV_W; k++) begin
      if (idx == k) begin
        tap_lvl  = cnt_nxt[k];
        tap_rise = rise_vec[k];
      end
    end
  end

endmodule

// File: rtl/osc_rate_gen.sv
module osc_rate_gen
  import osc_div_pkg::*;
#(
  parameter int DIV_W = 15,
  parameter int SEL_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              osc_tick,
  input  logic [CTRL_W-1:0] div_ctrl,
  input  logic [SEL_W-1:0]  rate_sel,
  input  logic              sq_en,
  output logic              sq_out,
  output logic              periodic_evt
);

  osc_mode_e        mode;
  logic [DIV_W-1:0] cnt_nxt;
  logic [DIV_W-1:0] rise_vec;
  logic             tap_lvl;
  logic             tap_rise;
  logic             sq_q;
  logic             evt_q;

  osc_div_ctrl u_ctrl (
    .div_ctrl (div_ctrl),
    .mode     (mode)
  );

  osc_div_chain #(.DIV_W(DIV_W)) u_chain (
    .clk      (clk),
    .rst      (rst),
    .osc_tick (osc_tick),
    .mode     (mode),
    .cnt_nxt  (cnt_nxt),
    .rise_vec (rise_vec)
  );

  osc_rate_mux #(.DIV_W(DIV_W), .SEL_W(SEL_W)) u_mux (
    .rate_sel (rate_sel),
    .cnt_nxt  (cnt_nxt),
    .rise_vec (rise_vec),
    .tap_lvl  (tap_lvl),
    .tap_rise (tap_rise)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      sq_q  <= 1'b0;
      evt_q <= 1'b0;
    end else begin
      sq_q  <= sq_en && (mode == OSC_RUN) && tap_lvl;
      evt_q <= (mode == OSC_RUN) && tap_rise;
    end
  end

  assign sq_out       = sq_q;
  assign periodic_evt = evt_q;

  // R7
  sq_gate_chk: assert property (@(posedge clk) disable iff (rst)
    !sq_en |=> !sq_out);

  // R6
  rate_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (rate_sel == '0) |=> !periodic_evt);

  // R8
  evt_single_chk: assert property (@(posedge clk) disable iff (rst)
    periodic_evt |=> !periodic_evt);

  // R3
  sq_needs_run_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(sq_out) |-> ($past(div_ctrl) == CTRL_RUN_PAT));

endmodule

// File: tb/test_osc_rate_gen.sv
module test_osc_rate_gen;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       osc_tick = 1'b0;
  logic [2:0] div_ctrl = 3'b010;
  logic [3:0] rate_sel = 4'd3;
  logic       sq_en = 1'b1;
  logic       sq_out;
  logic       periodic_evt;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  logic [14:0] m_cnt = '0;

  always #2.5 clk = ~clk;

  osc_rate_gen i_osc_rate_gen (
    .clk          (clk),
    .rst          (rst),
    .osc_tick     (osc_tick),
    .div_ctrl     (div_ctrl),
    .rate_sel     (rate_sel),
    .sq_en        (sq_en),
    .sq_out       (sq_out),
    .periodic_evt (periodic_evt)
  );

  function automatic int tap_of(input logic [3:0] code);
    if (code == 0) return -1;
    if (code == 1) return 6;
    if (code == 2) return 7;
    return int'(code) - 2;
  endfunction

  function automatic string auto_tag(input logic [2:0] c, input logic [3:0] r, input logic e);
    if (c[2:1] == 2'b11) return "R2";
    if (c != 3'b010) return "R3";
    if (r == 0) return "R6";
    if (!e) return "R7";
    if (r < 3) return "R4";
    return "R5";
  endfunction

  task automatic check(input string tag, input logic act_sq, input logic exp_sq,
                       input logic act_ev, input logic exp_ev);
    checks++;
    if (act_sq !== exp_sq || act_ev !== exp_ev) begin
      fails++;
      if (fails < 30)
        $display("FAIL %s: sq_out=%b exp %b periodic_evt=%b exp %b (t=%0t)",
                 tag, act_sq, exp_sq, act_ev, exp_ev, $time);
    end
  endtask

  // One clock of stimulus already applied; model next state and compare after the edge
  task automatic step(input string tag);
    logic [14:0] nx;
    bit run, hold, exp_sq, exp_ev;
    int t;
    run  = (div_ctrl == 3'b010);
    hold = (div_ctrl[2:1] == 2'b11);
    nx   = hold ? 15'd0 : ((run && osc_tick) ? m_cnt + 15'd1 : m_cnt);
    t    = tap_of(rate_sel);
    exp_sq = sq_en && run && (t >= 0) && nx[t];
    exp_ev = run && osc_tick && (t >= 0) && !m_cnt[t] && nx[t];
    @(posedge clk);
    m_cnt = nx;
    @(negedge clk);
    check(tag, sq_out, exp_sq, periodic_evt, exp_ev);
  endtask

  task automatic run_n(input int n, input string tag, input bit every);
    for (int i = 0; i < n; i++) begin
      osc_tick = every ? 1'b1 : (($urandom % 4) != 0);
      step(tag);
    end
  endtask

  initial begin
    void'($urandom(32'd1234));
    // R10: reset
    @(negedge clk);
    for (int i = 0; i < 3; i++) begin
      osc_tick = 1'b1;
      @(posedge clk);
      @(negedge clk);
      check("R10", sq_out, 1'b0, periodic_evt, 1'b0);
    end
    rst = 1'b0;
    m_cnt = '0;
    osc_tick = 1'b0;
    step("R10");

    // R1: counting at the fastest tap
    div_ctrl = 3'b010; rate_sel = 4'd3; sq_en = 1'b1;
    run_n(64, "R1", 1'b1);
    run_n(64, "R1", 1'b0);

    // R4: slow pair of codes
    rate_sel = 4'd1; run_n(400, "R4", 1'b1);
    rate_sel = 4'd2; run_n(600, "R4", 1'b1);

    // R5: every fast code
    for (int c = 3; c < 16; c++) begin
      rate_sel = 4'(c);
      run_n((1 << (c - 2)) + 8 > 2000 ? 2000 : (1 << (c - 2)) + 8, "R5", 1'b1);
    end
    rate_sel = 4'd15;
    run_n(17000, "R5", 1'b1);

    // R7: square wave disabled, event keeps running
    rate_sel = 4'd3; sq_en = 1'b0;
    run_n(200, "R7", 1'b1);
    sq_en = 1'b1;

    // R6: no tap
    rate_sel = 4'd0;
    run_n(200, "R6", 1'b1);

    // R9: rate change while the old tap is high
    rate_sel = 4'd3;
    while (!m_cnt[1]) begin osc_tick = 1'b1; step("R9"); end
    rate_sel = 4'd4;
    run_n(40, "R9", 1'b1);
    rate_sel = 4'd15;
    run_n(40, "R9", 1'b1);
    rate_sel = 4'd3;
    run_n(40, "R9", 1'b1);

    // R2: hold at zero, then restart
    div_ctrl = 3'b110; run_n(50, "R2", 1'b1);
    div_ctrl = 3'b111; run_n(50, "R2", 1'b1);
    div_ctrl = 3'b010; run_n(30, "R2", 1'b1);

    // R3: every off pattern keeps the count, resume afterwards
    begin
      logic [2:0] offs [5] = '{3'b000, 3'b001, 3'b011, 3'b100, 3'b101};
      for (int j = 0; j < 5; j++) begin
        run_n(5, "R3", 1'b1);
        div_ctrl = offs[j];
        run_n(40, "R3", 1'b1);
        div_ctrl = 3'b010;
      end
      run_n(40, "R3", 1'b1);
    end

    // Random mix
    for (int i = 0; i < 40000; i++) begin
      if (($urandom % 2000) == 0) div_ctrl = 3'($urandom % 8);
      if (($urandom % 3) == 0 && div_ctrl != 3'b010 && ($urandom % 50) == 0) div_ctrl = 3'b010;
      if (($urandom % 400) == 0) rate_sel = 4'($urandom % 16);
      if (($urandom % 300) == 0) sq_en = ~sq_en;
      osc_tick = (($urandom % 4) != 0);
      step(auto_tag(div_ctrl, rate_sel, sq_en));
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: run did not complete, actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule